// File: doc/BRIEF.md
# Four-Channel Line Interface Control Register Bank

This block is the host-visible register file for a four-channel line interface. A host reaches it over a simple synchronous register bus with an address, write data, a write strobe, a read strobe and registered read data. Each channel supplies two raw condition inputs: loss of signal and a second line-fault monitor. The block latches every change of either condition, in either direction, into a per-channel interrupt status bit. A read of a status register clears the bits it returned. A single interrupt output is high while any status bit is set.

The bank also holds three control registers. One holds per-channel digital loopback enables. One holds per-channel loss-of-signal criteria selects, which take effect only when the line runs in E1 mode. The third is a four-bit performance-monitor selection field. Any write to the reset address starts a self-reset. Its length is counted in system clock cycles from the `CLK_HZ` parameter: 1 µs normally, or 2 µs when the non-multiplexed host mode input is high at the time of the write. While it runs, every register is held at its all-zero default and writes are ignored.

Top module: `qli_ctrl_regs`

## Requirements
- R1: After `rst_n` is released, every register reads 00h, `lpbk_en`, `crit_sel`, `pmon_sel`, `irq` and `sw_rst_busy` are 0. A raw input held high through reset sets no status bit.
- R2: Bit n (n = 0..3) of the loss-of-signal status register at address 08h goes to 1 one cycle after `los_raw[n]` changes level, in either direction. It stays 1 until a read clears it.
- R3: Bit n of the fault status register at address 09h behaves the same way for `flt_raw[n]`.
- R4: A read of 08h or 09h returns the register's current value and clears exactly the returned bits. A change that is latched on the same clock edge as the read stays set.
- R5: Bits 3:0 written to address 0Ch drive `lpbk_en[3:0]`, one bit per channel, and read back from 0Ch.
- R6: Bits 3:0 written to address 0Dh are stored and read back from 0Dh. `crit_sel` equals the stored value while `e1_mode` is 1 and is 0 while `e1_mode` is 0.
- R7: Bits 3:0 written to address 0Bh drive `pmon_sel` and read back from 0Bh.
- R8: Bits 7:4 of every register read as 0. Reads of address 0Ah, or of any address other than 08h, 09h and 0Bh to 0Dh, return 00h. Writes to such addresses change no output.
- R9: Any write to address 0Ah clears all registers on the write's clock edge. It holds `sw_rst_busy` high for exactly CLK_HZ/1,000,000 cycles when `host_nonmux` is 0 at the write, and for twice that when it is 1.
- R10: While `sw_rst_busy` is high, writes to any address have no effect.
- R11: `irq` is 1 exactly when at least one bit of 08h or 09h is set.
- R12: `bus_rdata` changes only on the clock edge that samples `bus_rd` high, and then holds the addressed register's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, registered |
| host_nonmux | input | 1 | Selects the doubled self-reset length |
| e1_mode | input | 1 | 1 = E1 line mode, 0 = T1 line mode |
| los_raw | input | 4 | Raw loss-of-signal condition per channel |
| flt_raw | input | 4 | Raw line-fault monitor condition per channel |
| lpbk_en | output | 4 | Digital loopback enable per channel |
| crit_sel | output | 4 | Effective loss-of-signal criteria select per channel |
| pmon_sel | output | 4 | Performance-monitor selection field |
| irq | output | 1 | Any status bit set |
| sw_rst_busy | output | 1 | Self-reset in progress |

## Verification
The assertions check several rules on every cycle. A level change on a raw input is latched by the following edge. A set status bit survives every cycle that has no read and no self-reset. The self-reset counter never leaves its range and only starts after a write. Outputs stay at zero for as long as the self-reset runs. Only the bench scenarios can show the rest: the exact length of the self-reset in both host modes, the clear-on-read race in which a change lands on the read edge, and whether undefined addresses and writes blocked during the self-reset leave the outputs untouched.

// File: rtl/qli_regs_pkg.sv
// Package: register addresses and widths shared by the line-interface register bank.
// Assumes an 8-bit register bus; all registers hold at most four meaningful bits.
package qli_regs_pkg;
    localparam int unsigned BUS_W = 8;
    localparam int unsigned FIELD_W = 4;

    localparam logic [BUS_W-1:0] A_LOS_ST = 8'h08;
    localparam logic [BUS_W-1:0] A_FLT_ST = 8'h09;
    localparam logic [BUS_W-1:0] A_SWRST  = 8'h0A;
    localparam logic [BUS_W-1:0] A_PMON   = 8'h0B;
    localparam logic [BUS_W-1:0] A_LPBK   = 8'h0C;
    localparam logic [BUS_W-1:0] A_CRIT   = 8'h0D;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_LOS,
        SEL_FLT,
        SEL_PMON,
        SEL_LPBK,
        SEL_CRIT
    } reg_sel_e;
endpackage

// File: rtl/qli_chg_latch.sv
// Module: per-channel change latch with clear-on-read.
// Each bit goes to 1 when its raw input changes level and stays there until
// a read (rd_clr) or a bank-wide clear. A change seen on the read edge wins.
// Assumes raw inputs are already synchronous to clk.
module qli_chg_latch #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr_all,
    input  logic           rd_clr,
    input  logic [NCH-1:0] raw,
    output logic [NCH-1:0] stat
);
    logic [NCH-1:0] prev_q;

    // Track the previous raw level; during reset it follows raw so no edge is seen on release.
    always_ff @(posedge clk) begin
        prev_q <= raw;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic chg;
        assign chg = raw[i] ^ prev_q[i];

        // Latch a level change, clear on read or bank clear.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                stat[i] <= 1'b0;
            end else begin
                stat[i] <= (stat[i] && !rd_clr) || chg;
            end
        end

        AST_CHG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_all && raw[i] != $past(raw[i])) |=> stat[i]);  // R2 R3
        AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[i] && !rd_clr && !clr_all) |=> stat[i]);  // R4
    end
endmodule

// File: rtl/qli_rst_timer.sv
// Module: self-reset timer. A start pulse launches a busy window of
// CLK_HZ/1e6 cycles, doubled when long_mode is high at the start.
// Starts while busy are ignored. Assumes CLK_HZ is at least 1 MHz.
module qli_rst_timer #(
    parameter int unsigned CLK_HZ = 250_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_mode,
    output logic busy
);
    localparam int unsigned SHORT_CYC = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int unsigned LONG_CYC  = 2 * SHORT_CYC;
    localparam int unsigned CW        = $clog2(LONG_CYC + 1);
    localparam logic [CW-1:0] SHORT_M1 = CW'(SHORT_CYC - 1);
    localparam logic [CW-1:0] LONG_M1  = CW'(LONG_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Load the window length on start, count down, drop busy after the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= long_mode ? LONG_M1 : SHORT_M1;
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LONG_M1));  // R9
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));  // R9
endmodule

// File: rtl/qli_ctrl_regs.sv
// Module: host register bank for a four-channel line interface.
// Holds latched status for loss of signal and line fault, loopback enables,
// criteria selects and a monitor selection field; a write to the reset
// address runs a timed self-reset. Assumes one-cycle bus strobes and NCH <= 4.
module qli_ctrl_regs
    import qli_regs_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned CLK_HZ = 250_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]   bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [BUS_W-1:0]   bus_rdata,
    input  logic               host_nonmux,
    input  logic               e1_mode,
    input  logic [NCH-1:0]     los_raw,
    input  logic [NCH-1:0]     flt_raw,
    output logic [NCH-1:0]     lpbk_en,
    output logic [NCH-1:0]     crit_sel,
    output logic [FIELD_W-1:0] pmon_sel,
    output logic               irq,
    output logic               sw_rst_busy
);
    reg_sel_e       sel;
    logic           wr_ok;
    logic           bank_clr;
    logic [NCH-1:0] los_st;
    logic [NCH-1:0] flt_st;
    logic [NCH-1:0] crit_q;
    logic [BUS_W-1:0] rd_mux;
    logic           unused_wdata;

    assign unused_wdata = ^bus_wdata[BUS_W-1:FIELD_W];

    // Decode the bus address to a register select.
    always_comb begin
        unique case (bus_addr)
            A_LOS_ST: sel = SEL_LOS;
            A_FLT_ST: sel = SEL_FLT;
            A_PMON:   sel = SEL_PMON;
            A_LPBK:   sel = SEL_LPBK;
            A_CRIT:   sel = SEL_CRIT;
            default:  sel = SEL_NONE;
        endcase
    end

    assign wr_ok    = bus_wr && !sw_rst_busy;
    assign bank_clr = sw_rst_busy || (wr_ok && bus_addr == A_SWRST);

    qli_rst_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (wr_ok && bus_addr == A_SWRST),
        .long_mode (host_nonmux),
        .busy      (sw_rst_busy)
    );

    qli_chg_latch #(.NCH(NCH)) u_los (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (bank_clr),
        .rd_clr  (bus_rd && sel == SEL_LOS),
        .raw     (los_raw),
        .stat    (los_st)
    );

    qli_chg_latch #(.NCH(NCH)) u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (bank_clr),
        .rd_clr  (bus_rd && sel == SEL_FLT),
        .raw     (flt_raw),
        .stat    (flt_st)
    );

    // Control registers: cleared by reset or self-reset, loaded by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n || bank_clr) begin
            lpbk_en  <= '0;
            crit_q   <= '0;
            pmon_sel <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_LPBK) lpbk_en  <= bus_wdata[NCH-1:0];
            if (sel == SEL_CRIT) crit_q   <= bus_wdata[NCH-1:0];
            if (sel == SEL_PMON) pmon_sel <= bus_wdata[FIELD_W-1:0];
        end
    end

    // Read multiplexer; unused bits and unknown addresses return zero.
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_LOS:  rd_mux[NCH-1:0]     = los_st;
            SEL_FLT:  rd_mux[NCH-1:0]     = flt_st;
            SEL_PMON: rd_mux[FIELD_W-1:0] = pmon_sel;
            SEL_LPBK: rd_mux[NCH-1:0]     = lpbk_en;
            SEL_CRIT: rd_mux[NCH-1:0]     = crit_q;
            default:  rd_mux = '0;
        endcase
    end

    // Register read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    assign crit_sel = e1_mode ? crit_q : '0;
    assign irq      = |{los_st, flt_st};

    AST_BUSY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_busy |-> (lpbk_en == '0 && pmon_sel == '0 && crit_sel == '0 && !irq));  // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));  // R12
    AST_RDATA_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:FIELD_W] == '0);  // R8
endmodule

// File: tb/qli_ctrl_regs_tb.sv
// Bench: directed corner cases plus seeded random register traffic, checked
// against a behavioural model kept in bench variables.
module qli_ctrl_regs_tb_top;
    localparam int unsigned CLK_HZ = 250_000_000;
    localparam int SHORT_CYC = CLK_HZ / 1_000_000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       host_nonmux = 1'b0;
    logic       e1_mode = 1'b0;
    logic [3:0] los_raw = 4'h0;
    logic [3:0] flt_raw = 4'h0;
    logic [3:0] lpbk_en;
    logic [3:0] crit_sel;
    logic [3:0] pmon_sel;
    logic       irq;
    logic       sw_rst_busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [3:0] m_los, m_flt, m_lb, m_cr, m_mon;

    always #2 clk = ~clk;

    qli_ctrl_regs #(.NCH(4), .CLK_HZ(CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .host_nonmux(host_nonmux), .e1_mode(e1_mode), .los_raw(los_raw),
        .flt_raw(flt_raw), .lpbk_en(lpbk_en), .crit_sel(crit_sel),
        .pmon_sel(pmon_sel), .irq(irq), .sw_rst_busy(sw_rst_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'h08: return {4'h0, m_los};
            8'h09: return {4'h0, m_flt};
            8'h0B: return {4'h0, m_mon};
            8'h0C: return {4'h0, m_lb};
            8'h0D: return {4'h0, m_cr};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_outputs(input string tag);
        check({tag, " R5 lpbk_en"}, lpbk_en, m_lb);
        check({tag, " R6 crit_sel"}, crit_sel, e1_mode ? m_cr : 4'h0);
        check({tag, " R7 pmon_sel"}, pmon_sel, m_mon);
        check({tag, " R11 irq"}, irq, (|{m_los, m_flt}) ? 1 : 0);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a)
            8'h0A: begin m_los = 0; m_flt = 0; m_lb = 0; m_cr = 0; m_mon = 0; end
            8'h0B: m_mon = d[3:0];
            8'h0C: m_lb = d[3:0];
            8'h0D: m_cr = d[3:0];
            default: ;
        endcase
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [7:0] e;
        e = exp_read(a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check({req, " read"}, bus_rdata, e);
        if (a == 8'h08) m_los = 0;
        if (a == 8'h09) m_flt = 0;
    endtask

    task automatic set_raw(input logic [3:0] l, input logic [3:0] f);
        @(negedge clk);
        m_los |= l ^ los_raw;
        m_flt |= f ^ flt_raw;
        los_raw = l; flt_raw = f;
    endtask

    task automatic soft_reset(input bit longm, input int exp_len, input string req);
        int n;
        host_nonmux = longm;
        do_write(8'h0A, 8'h5A);
        check({req, " cleared lpbk"}, lpbk_en, 0);
        check({req, " cleared irq"}, irq, 0);
        host_nonmux = 1'b0;
        n = 1;
        bus_addr = 8'h0C; bus_wdata = 8'h0F; bus_wr = 1'b1;  // R10 blocked write
        @(negedge clk);
        bus_wr = 1'b0;
        while (sw_rst_busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
        check({req, " busy length"}, n, exp_len);
        check("R10 write during busy ignored", lpbk_en, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_los = 0; m_flt = 0; m_lb = 0; m_cr = 0; m_mon = 0;
        los_raw = 4'hF; flt_raw = 4'hA;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata", bus_rdata, 0);
        check("R1 busy", sw_rst_busy, 0);
        check_outputs("R1");
        do_read(8'h08, "R1 no spurious los");
        do_read(8'h09, "R1 no spurious flt");

        // R2 / R3 both directions
        set_raw(4'hE, 4'hA);
        set_raw(4'hE, 4'hB);
        @(negedge clk);
        check("R11 irq set", irq, 1);
        do_read(8'h08, "R2 falling los");
        do_read(8'h09, "R3 rising flt");
        do_read(8'h08, "R4 cleared after read");
        check("R11 irq clear", irq, 0);

        // R4 race: change on the read edge stays set
        set_raw(4'hC, 4'hB);
        @(negedge clk);
        bus_addr = 8'h08; bus_rd = 1'b1;
        los_raw = 4'hD;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R4 race read returns old", bus_rdata, 8'h02);
        m_los = 4'h1;
        do_read(8'h08, "R4 race change kept");

        // R5-R7 directed
        do_write(8'h0C, 8'hF5);
        do_write(8'h0D, 8'h96);
        do_write(8'h0B, 8'hA9);
        e1_mode = 1'b0;
        @(negedge clk);
        check_outputs("T1");
        check("R6 T1 crit forced zero", crit_sel, 0);
        e1_mode = 1'b1;
        @(negedge clk);
        check("R6 E1 crit", crit_sel, 4'h6);
        do_read(8'h0C, "R5 R8");
        do_read(8'h0D, "R6");
        do_read(8'h0B, "R7");
        do_read(8'h0A, "R8 reset reg");
        do_read(8'h3F, "R8 undefined");
        do_write(8'h0E, 8'hFF);
        check_outputs("R8 undefined write");

        // R12 hold
        do_read(8'h0C, "R12 setup");
        do_write(8'h0C, 8'h03);
        @(negedge clk);
        check("R12 rdata held", bus_rdata, 8'h05);

        // R9 / R10
        set_raw(4'h0, 4'h0);
        soft_reset(1'b0, SHORT_CYC, "R9 short");
        check_outputs("R9 after short");
        do_read(8'h08, "R9 status cleared");
        do_write(8'h0C, 8'h0A);
        soft_reset(1'b1, 2 * SHORT_CYC, "R9 long");
        do_read(8'h0C, "R9 lpbk cleared");

        // Random traffic
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: set_raw(4'($urandom), 4'($urandom));
                1: begin
                    logic [7:0] a;
                    case ($urandom_range(0, 3))
                        0: a = 8'h0B;
                        1: a = 8'h0C;
                        2: a = 8'h0D;
                        default: a = 8'($urandom_range(8'h0E, 8'hFF));
                    endcase
                    do_write(a, 8'($urandom));
                end
                2: begin
                    logic [7:0] a;
                    case ($urandom_range(0, 6))
                        0: a = 8'h08;
                        1: a = 8'h09;
                        2: a = 8'h0B;
                        3: a = 8'h0C;
                        4: a = 8'h0D;
                        5: a = 8'h0A;
                        default: a = 8'($urandom_range(0, 7));
                    endcase
                    do_read(a, "R2 R3 R4 R8 random");
                end
                default: begin
                    @(negedge clk);
                    e1_mode = ~e1_mode;
                end
            endcase
            @(negedge clk);
            check_outputs("random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule